// File: doc/BRIEF.md
# Prefetch Request Queue

This block holds the prefetch requests that are waiting to go out beside a cache controller. An external address generator offers candidate addresses over a valid/ready handshake. Each candidate carries a base time and a delay. The block first reduces each address to its cache-block address. It then drops candidates that are already covered elsewhere. Survivors are appended in arrival order with a ready timestamp, and the block raises a request toward the bus arbiter. That request carries the ready time of the oldest entry. When the cache's bus port asks for a prefetch, the block hands out the oldest useful entry.

Demand misses act on the queue as well. An accepted miss removes any queued prefetch to the same block. In serial-squash mode the miss also cuts from the newest end every entry whose ready time is at or after the miss time. The cache-presence lookup is checked in one of two places, chosen by a mode input: either at insertion, or when an entry is handed out. The queue is bounded. A candidate that arrives while the queue is full pushes out the oldest entry. Statistics counters record every kind of drop, removal and issue.

Top module: `pf_request_queue`

## Requirements
- R1: Every stored, presented and issued address is a block address: the low log2(BLK_BYTES) bits are cleared (default 6 bits for 64-byte blocks).
- R2: A miss is ignored when `miss_uncached` is set, or when `miss_ifetch` and `cfg_data_only` are both set. An ignored miss leaves the queue and every counter unchanged.
- R3: An accepted miss removes the queued entry with the same block address, if there is one, and adds one to `stat_cancelled`.
- R4: With `cfg_serial_squash` set, an accepted miss at time T then removes entries from the newest end while the newest entry's ready time is greater than or equal to T. Each removed entry adds one to `stat_squashed`.
- R5: An inserted entry's ready time is `cand_base_time + cand_delay`. `pf_req_time` shows the ready time of the oldest queued entry.
- R6: Every accepted candidate adds one to `stat_identified`. A candidate with `cand_in_missq` set is dropped and counted in `stat_missq_drop`. A candidate whose block is already queued is dropped and counted in `stat_dup_drop`. The queue never holds two entries with the same block address.
- R7: With `cfg_push_check` set, a candidate with `cand_in_cache` set is dropped and counted in `stat_cache_drop`. This check comes before every other candidate check.
- R8: A candidate inserted into a queue that already holds DEPTH entries first discards the oldest entry and adds one to `stat_evicted`. The fill never exceeds DEPTH.
- R9: `pf_req` is high exactly when the queue holds at least one entry.
- R10: A pulse on `issue_req` pops entries from the head in arrival order. With `cfg_push_check` clear, a popped entry with `head_in_cache` set is discarded and the next entry is tried. The first entry that is kept is returned as a one-cycle `pf_out_valid` pulse with `pf_out_addr`, and `stat_issued` goes up by one.
- R11: An issue that finds the queue empty, whether at the start or after discards, gives a one-cycle `pf_out_none` pulse and no `pf_out_valid`.
- R12: A cycle with `miss_valid` high handles only the miss: `cand_ready` is low, and a pending issue waits for the next cycle, so it sees the queue after the miss. While an issue is pending, `cand_ready` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial_squash | input | 1 | Miss squashes newer entries from the tail |
| cfg_push_check | input | 1 | 1: cache presence checked at insertion; 0: at issue |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| miss_valid | input | 1 | Demand miss notification |
| miss_addr | input | AW | Miss address |
| miss_time | input | TW | Miss time |
| miss_uncached | input | 1 | Miss access is uncacheable |
| miss_ifetch | input | 1 | Miss access is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | AW | Candidate address |
| cand_base_time | input | TW | Time the candidate's delay counts from |
| cand_delay | input | DW | Candidate delay |
| cand_in_cache | input | 1 | Cache lookup hit for the candidate block |
| cand_in_missq | input | 1 | Miss-queue lookup hit (block and address space) |
| issue_req | input | 1 | Bus port asks for a prefetch |
| head_addr | output | AW | Block address of the oldest entry, for the cache lookup |
| head_in_cache | input | 1 | Cache lookup hit for `head_addr` |
| pf_out_valid | output | 1 | Issued prefetch pulse |
| pf_out_none | output | 1 | Issue found nothing pulse |
| pf_out_addr | output | AW | Issued block address |
| pf_req | output | 1 | Prefetch request toward the arbiter |
| pf_req_time | output | TW | Ready time of the oldest entry |
| stat_identified | output | CNT_W | Candidates accepted |
| stat_missq_drop | output | CNT_W | Candidates dropped for a miss-queue hit |
| stat_cache_drop | output | CNT_W | Candidates dropped for a cache hit at insertion |
| stat_dup_drop | output | CNT_W | Candidates dropped as already queued |
| stat_evicted | output | CNT_W | Oldest entries displaced by a full queue |
| stat_cancelled | output | CNT_W | Entries removed by a matching miss |
| stat_squashed | output | CNT_W | Entries removed by serial squash |
| stat_issued | output | CNT_W | Prefetches handed out |

## Verification
Several properties are checked on every cycle: the fill bound, the uniqueness of queued block addresses, the link between the request flag and the fill, the alignment of issued addresses, the exclusion between the two issue outcomes, the blocking of candidates by a miss, and the issued counter rising with each issue pulse. The order of entries, the squash cut point, eviction of the oldest entry, the skipping of cached entries at issue, and the counters' values against each kind of drop are visible only across a sequence of operations. The bench shows these by running a reference queue model alongside the design under mixed random and directed stimulus.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam int STAT_N      = 8;
  localparam int S_IDENT     = 0;
  localparam int S_MISSQ     = 1;
  localparam int S_CACHE     = 2;
  localparam int S_DUP       = 3;
  localparam int S_EVICT     = 4;
  localparam int S_CANCEL    = 5;
  localparam int S_SQUASH    = 6;
  localparam int S_ISSUE     = 7;
endpackage

// File: rtl/prq_lookup.sv
// Parallel block-address match over the filled part of the queue.
module prq_lookup #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int CW    = 4
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [CW-1:0]            fill,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [CW-1:0]            idx
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = (CW'(g) < fill) && (ent_addr[g] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/prq_squash_scan.sv
// Finds how many head-side entries survive a tail squash at a given time.
module prq_squash_scan #(
  parameter int DEPTH = 8,
  parameter int TW    = 16,
  parameter int CW    = 4
) (
  input  logic [DEPTH-1:0][TW-1:0] ent_time,
  input  logic [CW-1:0]            fill,
  input  logic [TW-1:0]            limit,
  output logic [CW-1:0]            keep
);
  always_comb begin
    keep = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < fill) && (ent_time[i] < limit)) keep = CW'(i + 1);
    end
  end
endmodule

// File: rtl/prq_counters.sv
// Bank of statistics counters, each advanced by a small increment.
module prq_counters #(
  parameter int N     = 8,
  parameter int CNT_W = 16,
  parameter int IW    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0][IW-1:0]    inc,
  output logic [N-1:0][CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] c_r [N];

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) c_r[g] <= '0;
      else     c_r[g] <= c_r[g] + CNT_W'(inc[g]);
    end
    assign cnt[g] = c_r[g];
  end
endmodule

// File: rtl/pf_request_queue.sv
module pf_request_queue
  import prq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int TW        = 16,
  parameter int DW        = 8,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_serial_squash,
  input  logic             cfg_push_check,
  input  logic             cfg_data_only,
  input  logic             miss_valid,
  input  logic [AW-1:0]    miss_addr,
  input  logic [TW-1:0]    miss_time,
  input  logic             miss_uncached,
  input  logic             miss_ifetch,
  input  logic             cand_valid,
  output logic             cand_ready,
  input  logic [AW-1:0]    cand_addr,
  input  logic [TW-1:0]    cand_base_time,
  input  logic [DW-1:0]    cand_delay,
  input  logic             cand_in_cache,
  input  logic             cand_in_missq,
  input  logic             issue_req,
  output logic [AW-1:0]    head_addr,
  input  logic             head_in_cache,
  output logic             pf_out_valid,
  output logic             pf_out_none,
  output logic [AW-1:0]    pf_out_addr,
  output logic             pf_req,
  output logic [TW-1:0]    pf_req_time,
  output logic [CNT_W-1:0] stat_identified,
  output logic [CNT_W-1:0] stat_missq_drop,
  output logic [CNT_W-1:0] stat_cache_drop,
  output logic [CNT_W-1:0] stat_dup_drop,
  output logic [CNT_W-1:0] stat_evicted,
  output logic [CNT_W-1:0] stat_cancelled,
  output logic [CNT_W-1:0] stat_squashed,
  output logic [CNT_W-1:0] stat_issued
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] BLK_MASK = ~AW'(BLK_BYTES - 1);
  localparam logic [CW-1:0] FULL     = CW'(DEPTH);

  // Queue storage: slot 0 is the oldest entry, slots below cnt are live.
  logic [DEPTH-1:0][AW-1:0] q_addr, n_addr, a1, sh_addr;
  logic [DEPTH-1:0][TW-1:0] q_time, n_time, t1, sh_time;
  logic [CW-1:0]            cnt, n_cnt, cnt1, cnt2, keep;
  logic                     iss_pend, n_pend;
  logic                     n_out_valid, n_out_none;
  logic [AW-1:0]            n_out_addr;

  logic [AW-1:0] miss_blk, cand_blk;
  logic          miss_take, iss_active, iss_step, cand_take;
  logic          m_hit, c_hit;
  logic [CW-1:0] m_idx, c_idx;
  logic [STAT_N-1:0][CW-1:0]    inc;
  logic [STAT_N-1:0][CNT_W-1:0] stats;

  assign miss_blk   = miss_addr & BLK_MASK;
  assign cand_blk   = cand_addr & BLK_MASK;
  assign miss_take  = miss_valid & ~miss_uncached & ~(miss_ifetch & cfg_data_only);
  assign iss_active = iss_pend | issue_req;
  // A miss owns its cycle; an issue in progress owns the rest.
  assign iss_step   = iss_active & ~miss_valid;
  assign cand_ready = ~miss_valid & ~iss_active;
  assign cand_take  = cand_valid & cand_ready;
  assign head_addr  = q_addr[0];

  // Contents shifted one slot toward the head.
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign sh_addr[g] = q_addr[g+1];
      assign sh_time[g] = q_time[g+1];
    end else begin : g_end
      assign sh_addr[g] = '0;
      assign sh_time[g] = '0;
    end
  end

  prq_lookup #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_miss_lu (
    .ent_addr(q_addr), .fill(cnt), .key(miss_blk), .hit(m_hit), .idx(m_idx)
  );

  prq_lookup #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cand_lu (
    .ent_addr(q_addr), .fill(cnt), .key(cand_blk), .hit(c_hit), .idx(c_idx)
  );

  // Miss stage one: close the gap left by a cancelled entry.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (m_hit && (CW'(i) >= m_idx)) begin
        a1[i] = sh_addr[i];
        t1[i] = sh_time[i];
      end else begin
        a1[i] = q_addr[i];
        t1[i] = q_time[i];
      end
    end
    cnt1 = cnt - CW'(m_hit);
  end

  // Miss stage two: tail squash over the post-cancel contents.
  prq_squash_scan #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_squash (
    .ent_time(t1), .fill(cnt1), .limit(miss_time), .keep(keep)
  );

  assign cnt2 = cfg_serial_squash ? keep : cnt1;

  always_comb begin
    logic [CW-1:0] wpos;
    n_addr      = q_addr;
    n_time      = q_time;
    n_cnt       = cnt;
    n_pend      = iss_active;
    n_out_valid = 1'b0;
    n_out_none  = 1'b0;
    n_out_addr  = pf_out_addr;
    inc         = '0;
    wpos        = cnt;
    if (miss_take) begin
      n_addr           = a1;
      n_time           = t1;
      n_cnt            = cnt2;
      inc[S_CANCEL]    = CW'(m_hit);
      inc[S_SQUASH]    = cnt1 - cnt2;
    end else if (iss_step) begin
      if (cnt == '0) begin
        n_out_none = 1'b1;
        n_pend     = 1'b0;
      end else begin
        n_addr = sh_addr;
        n_time = sh_time;
        n_cnt  = cnt - CW'(1);
        if (!cfg_push_check && head_in_cache) begin
          n_pend = 1'b1;
        end else begin
          n_out_valid   = 1'b1;
          n_out_addr    = q_addr[0];
          inc[S_ISSUE]  = CW'(1);
          n_pend        = 1'b0;
        end
      end
    end else if (cand_take) begin
      inc[S_IDENT] = CW'(1);
      if (cfg_push_check && cand_in_cache) begin
        inc[S_CACHE] = CW'(1);
      end else if (cand_in_missq) begin
        inc[S_MISSQ] = CW'(1);
      end else if (c_hit) begin
        inc[S_DUP] = CW'(1);
      end else begin
        if (cnt == FULL) begin
          n_addr       = sh_addr;
          n_time       = sh_time;
          inc[S_EVICT] = CW'(1);
          wpos         = FULL - CW'(1);
        end
        for (int i = 0; i < DEPTH; i++) begin
          if (CW'(i) == wpos) begin
            n_addr[i] = cand_blk;
            n_time[i] = cand_base_time + TW'(cand_delay);
          end
        end
        n_cnt = wpos + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr       <= '0;
      q_time       <= '0;
      cnt          <= '0;
      iss_pend     <= 1'b0;
      pf_out_valid <= 1'b0;
      pf_out_none  <= 1'b0;
      pf_out_addr  <= '0;
      pf_req       <= 1'b0;
      pf_req_time  <= '0;
    end else begin
      q_addr       <= n_addr;
      q_time       <= n_time;
      cnt          <= n_cnt;
      iss_pend     <= n_pend;
      pf_out_valid <= n_out_valid;
      pf_out_none  <= n_out_none;
      pf_out_addr  <= n_out_addr;
      pf_req       <= (n_cnt != '0);
      pf_req_time  <= n_time[0];
    end
  end

  prq_counters #(.N(STAT_N), .CNT_W(CNT_W), .IW(CW)) u_stats (
    .clk(clk), .rst(rst), .inc(inc), .cnt(stats)
  );

  assign stat_identified = stats[S_IDENT];
  assign stat_missq_drop = stats[S_MISSQ];
  assign stat_cache_drop = stats[S_CACHE];
  assign stat_dup_drop   = stats[S_DUP];
  assign stat_evicted    = stats[S_EVICT];
  assign stat_cancelled  = stats[S_CANCEL];
  assign stat_squashed   = stats[S_SQUASH];
  assign stat_issued     = stats[S_ISSUE];

  // Pairwise duplicate scan over live entries, used only by the checks.
  logic dup_flag;
  always_comb begin
    dup_flag = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if ((CW'(j) < cnt) && (q_addr[i] == q_addr[j])) dup_flag = 1'b1;
      end
    end
  end

  a_r8_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  a_r6_unique_blocks: assert property (@(posedge clk) disable iff (rst)
    !dup_flag);
  a_r9_req_tracks_fill: assert property (@(posedge clk) disable iff (rst)
    pf_req == (cnt != '0));
  a_r1_issued_aligned: assert property (@(posedge clk) disable iff (rst)
    pf_out_valid |-> (pf_out_addr[OFS_W-1:0] == '0));
  a_r11_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(pf_out_valid && pf_out_none));
  a_r12_miss_blocks_cand: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !cand_ready);
  a_r10_issue_counted: assert property (@(posedge clk) disable iff (rst)
    pf_out_valid |-> (stat_issued == $past(stat_issued) + CNT_W'(1)));
endmodule

// File: tb/pf_request_queue_bench.sv
module pf_request_queue_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int TW    = 16;
  localparam int DW    = 8;
  localparam int CNT_W = 16;
  localparam logic [31:0] MASK = 32'hFFFF_FFC0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_serial_squash = 0, cfg_push_check = 0, cfg_data_only = 0;
  logic miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [TW-1:0] miss_time = '0;
  logic cand_valid = 0, cand_in_cache = 0, cand_in_missq = 0;
  logic cand_ready;
  logic [AW-1:0] cand_addr = '0;
  logic [TW-1:0] cand_base_time = '0;
  logic [DW-1:0] cand_delay = '0;
  logic issue_req = 0;
  logic [AW-1:0] head_addr;
  logic head_in_cache;
  logic hic_en = 0;
  logic pf_out_valid, pf_out_none, pf_req;
  logic [AW-1:0] pf_out_addr;
  logic [TW-1:0] pf_req_time;
  logic [CNT_W-1:0] st [8];

  always #5 clk = ~clk;
  // Bench cache model: a block is present when address bit 8 is set.
  assign head_in_cache = hic_en & head_addr[8];

  pf_request_queue u_pf_request_queue (
    .clk(clk), .rst(rst),
    .cfg_serial_squash(cfg_serial_squash), .cfg_push_check(cfg_push_check),
    .cfg_data_only(cfg_data_only),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_time(miss_time),
    .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
    .cand_base_time(cand_base_time), .cand_delay(cand_delay),
    .cand_in_cache(cand_in_cache), .cand_in_missq(cand_in_missq),
    .issue_req(issue_req), .head_addr(head_addr), .head_in_cache(head_in_cache),
    .pf_out_valid(pf_out_valid), .pf_out_none(pf_out_none), .pf_out_addr(pf_out_addr),
    .pf_req(pf_req), .pf_req_time(pf_req_time),
    .stat_identified(st[0]), .stat_missq_drop(st[1]), .stat_cache_drop(st[2]),
    .stat_dup_drop(st[3]), .stat_evicted(st[4]), .stat_cancelled(st[5]),
    .stat_squashed(st[6]), .stat_issued(st[7])
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] m_addr[$];
  logic [15:0] m_time[$];
  int exp_stat[8];
  string stat_tag[8] = '{"R6 identified", "R6 missq_drop", "R7 cache_drop",
                         "R6 dup_drop", "R8 evicted", "R3 cancelled",
                         "R4 squashed", "R10 issued"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(logic [31:0] blk);
    for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == blk) return i;
    return -1;
  endfunction

  task automatic check_state();
    chk("R9 pf_req", 32'(pf_req), 32'(m_addr.size() != 0));
    if (m_addr.size() != 0) begin
      chk("R5 pf_req_time", 32'(pf_req_time), 32'(m_time[0]));
      chk("R1 head_addr", head_addr, m_addr[0]);
    end
    for (int k = 0; k < 8; k++) chk(stat_tag[k], 32'(st[k]), 32'(exp_stat[k]));
  endtask

  task automatic model_cand(logic [31:0] a, logic [15:0] base, logic [7:0] dly,
                            logic inc, logic inm);
    logic [31:0] blk = a & MASK;
    exp_stat[0]++;
    if (cfg_push_check && inc) exp_stat[2]++;
    else if (inm) exp_stat[1]++;
    else if (find(blk) >= 0) exp_stat[3]++;
    else begin
      if (m_addr.size() == DEPTH) begin
        void'(m_addr.pop_front()); void'(m_time.pop_front()); exp_stat[4]++;
      end
      m_addr.push_back(blk);
      m_time.push_back(base + 16'(dly));
    end
  endtask

  task automatic model_miss(logic [31:0] a, logic [15:0] t, logic unc, logic ifx);
    int idx;
    if (unc || (ifx && cfg_data_only)) return;
    idx = find(a & MASK);
    if (idx >= 0) begin
      m_addr.delete(idx); m_time.delete(idx); exp_stat[5]++;
    end
    if (cfg_serial_squash)
      while (m_addr.size() > 0 && m_time[m_time.size()-1] >= t) begin
        void'(m_addr.pop_back()); void'(m_time.pop_back()); exp_stat[6]++;
      end
  endtask

  task automatic model_issue(output logic v, output logic [31:0] a);
    v = 0; a = '0;
    while (m_addr.size() > 0) begin
      logic [31:0] h;
      h = m_addr.pop_front(); void'(m_time.pop_front());
      if (!cfg_push_check && hic_en && h[8]) continue;
      v = 1; a = h; exp_stat[7]++;
      break;
    end
  endtask

  task automatic do_cand(logic [31:0] a, logic [15:0] base, logic [7:0] dly,
                         logic inc, logic inm);
    @(negedge clk);
    cand_valid = 1; cand_addr = a; cand_base_time = base; cand_delay = dly;
    cand_in_cache = inc; cand_in_missq = inm;
    @(posedge clk);
    @(negedge clk);
    cand_valid = 0;
    model_cand(a, base, dly, inc, inm);
    check_state();
  endtask

  task automatic do_miss(logic [31:0] a, logic [15:0] t, logic unc, logic ifx);
    @(negedge clk);
    miss_valid = 1; miss_addr = a; miss_time = t; miss_uncached = unc; miss_ifetch = ifx;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0;
    model_miss(a, t, unc, ifx);
    check_state();
  endtask

  task automatic wait_issue(logic ev, logic [31:0] ea);
    logic got = 0;
    for (int k = 0; k < DEPTH + 4 && !got; k++) begin
      if (pf_out_valid || pf_out_none) got = 1;
      else @(negedge clk);
    end
    chk("R10 issue valid", 32'(pf_out_valid), 32'(ev));
    chk("R11 issue none", 32'(pf_out_none), 32'(!ev));
    if (ev) chk("R10 issue addr", pf_out_addr, ea);
    check_state();
  endtask

  task automatic do_issue();
    logic ev; logic [31:0] ea;
    @(negedge clk);
    issue_req = 1;
    @(posedge clk);
    @(negedge clk);
    issue_req = 0;
    model_issue(ev, ea);
    wait_issue(ev, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ev; logic [31:0] ea;
    void'($urandom(32'd7));
    for (int k = 0; k < 8; k++) exp_stat[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // Reset state
    chk("R9 reset pf_req", 32'(pf_req), 0);
    chk("R11 reset out", 32'(pf_out_valid | pf_out_none), 0);
    chk("R12 reset cand_ready", 32'(cand_ready), 1);
    check_state();

    // R11: issue on empty queue
    do_issue();

    // R1/R5: alignment and ready time
    do_cand(32'h1234_5677, 16'd10, 8'd5, 0, 0);
    chk("R5 ready time 15", 32'(pf_req_time), 32'd15);
    chk("R1 masked head", head_addr, 32'h1234_5640);
    do_issue();

    // R8: overfill by one, oldest goes
    for (int i = 0; i <= DEPTH; i++) do_cand(32'(i) << 9, 16'(i), 8'd1, 0, 0);
    chk("R8 one eviction", 32'(st[4]), 32'(exp_stat[4]));
    chk("R8 head is second", head_addr, 32'h200);

    // R6: duplicate and miss-queue drops
    do_cand(32'h0000_0A3F, 16'd0, 8'd0, 0, 0);
    do_cand(32'h0000_7000, 16'd0, 8'd0, 0, 1);

    // R3: cancel of a queued entry in the middle
    do_miss(32'h0000_0810, 16'd0, 0, 0);

    // R2: ignored misses leave everything alone
    cfg_data_only = 1;
    do_miss(32'h0000_0600, 16'd0, 0, 1);
    do_miss(32'h0000_0C00, 16'd0, 1, 0);
    chk("R2 ignored miss cancel count", 32'(st[5]), 32'd1);
    cfg_data_only = 0;

    // R4: serial squash cuts the tail at ready time >= 6
    cfg_serial_squash = 1;
    do_miss(32'h0007_0000, 16'd6, 0, 0);
    chk("R4 squash count", 32'(st[6]), 32'(exp_stat[6]));
    cfg_serial_squash = 0;

    // R7: insertion-side cache check comes first
    cfg_push_check = 1;
    do_cand(32'h0000_0400, 16'd0, 8'd0, 1, 1);
    chk("R7 cache drop first", 32'(st[2]), 32'd1);
    cfg_push_check = 0;

    // R10: issue-side skipping of cached entries (bit 8 set means cached)
    hic_en = 1;
    do_cand(32'h0001_0100, 16'd50, 8'd0, 0, 0);
    do_issue(); do_issue(); do_issue(); do_issue();
    hic_en = 0;

    // R12: miss and issue in one cycle; miss applied first
    while (m_addr.size() > 0) do_issue();
    do_cand(32'h0000_1000, 16'd1, 8'd0, 0, 0);
    do_cand(32'h0000_2000, 16'd2, 8'd0, 0, 0);
    @(negedge clk);
    miss_valid = 1; miss_addr = 32'h0000_1004; miss_time = 16'd0;
    miss_uncached = 0; miss_ifetch = 0; issue_req = 1; cand_valid = 1;
    cand_addr = 32'h0000_3000;
    #1 chk("R12 cand_ready low under miss", 32'(cand_ready), 0);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0; issue_req = 0; cand_valid = 0;
    model_miss(32'h0000_1004, 16'd0, 0, 0);
    model_issue(ev, ea);
    chk("R12 miss-first result", 32'(ea), 32'h0000_2000);
    wait_issue(ev, ea);

    // Random mix
    for (int seg = 0; seg < 4; seg++) begin
      cfg_serial_squash = $urandom_range(0, 1);
      cfg_push_check    = $urandom_range(0, 1);
      cfg_data_only     = $urandom_range(0, 1);
      hic_en            = $urandom_range(0, 1);
      for (int n = 0; n < 120; n++) begin
        int op = $urandom_range(0, 9);
        logic [31:0] ra = ($urandom_range(0, 15) << 6) | $urandom_range(0, 63);
        if (op < 6)
          do_cand(ra, 16'($urandom_range(0, 200)), 8'($urandom_range(0, 50)),
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0));
        else if (op < 8)
          do_miss(ra, 16'($urandom_range(0, 250)), ($urandom_range(0, 5) == 0),
                  $urandom_range(0, 1));
        else
          do_issue();
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule